// File: doc/BRIEF.md
# Tilt cartridge register file

This block is the register interface of a cartridge that carries a two-axis tilt sensor and a small serial EEPROM. It sits on an 8-bit CPU bus with a 16-bit address. Three low address regions hold the control keys: a ROM bank select and two separate enable keys. The register window at 0xA000–0xBFFF only answers once both keys are set. Inside the window, bits [7:4] of the address pick one of sixteen registers.

When the window is open, software starts a sensor sample with two writes. The first is a pattern write to register 0x0 and the second is a pattern write to register 0x1. A sample strobe then goes to the sensor. The raw 16-bit readings present during that strobe are negated, offset to a centre of 0x81D0, and held. The CPU reads them back byte by byte. Register 0x8 is a bit-level port to an external serial EEPROM: writes drive chip select, clock and data-in, and reads return them together with the device's data-out line. The EEPROM protocol itself runs in software.

The unlock logic is a four-state machine: LOCKED, KEY_A (only the first key set), KEY_B (only the second key set) and OPEN. Its transitions are key-A accept, key-A reject (to LOCKED from any state), key-B accept and key-B reject. The sample sequencer is a three-state machine: IDLE, ARMED and FIRE. Its transitions are arm (a good register-0 pattern), disarm (a bad register-0 pattern), fire (ARMED plus a good register-1 pattern), abort (ARMED plus a bad register-1 pattern) and a fixed FIRE to IDLE after one cycle.

Top module: `tiltcart_regs`

## Requirements
- R1: After reset the ROM bank reads 1, both keys are clear, the sequencer is IDLE, `sample_stb` is 0, `eep_pins` is 0x00 and `bus_rdata` is 0xFF.
- R2: A write in 0x0000–0x1FFF with data 0x0A sets key A. A write there with any other value clears both keys.
- R3: A write in 0x4000–0x5FFF with data 0x40 sets key B. A write there with any other value clears key B only.
- R4: A write in 0x2000–0x3FFF loads the ROM bank with the data ANDed with 0x7F. The bank changes on no other write.
- R5: Unless both keys are set, any read of 0xA000–0xBFFF returns 0xFF. Writes there change neither `eep_pins` nor the sequencer, and they produce no strobe.
- R6: A window write to register 0x0 arms the sequencer only if data bits 0, 2, 4 and 6 (mask 0x55) are all 1. Otherwise it disarms it. Writes to other registers leave the arm state alone.
- R7: A register 0x1 write while armed raises `sample_stb` for exactly the next cycle if data bits 1, 3, 5 and 7 (mask 0xAA) are all 1. Any register 0x1 write leaves the sequencer disarmed.
- R8: While `sample_stb` is high, the tilt holding registers capture (0x81D0 − raw) modulo 2^16 for each axis. They hold that value at all other times.
- R9: Register 0x2 reads the X low byte and 0x3 the X high byte. Register 0x4 reads the Y low byte and 0x5 the Y high byte.
- R10: Register 0x6 reads 0x00. Registers 0x0, 0x1, 0x7 and 0x9–0xF read 0xFF.
- R11: A write to register 0x8 stores data bits 7 (chip select), 6 (clock) and 1 (data-in) onto the same bits of `eep_pins`, whose other bits are 0. A read of register 0x8 returns those bits with `eep_dout` in bit 0.
- R12: `bus_rdata` takes the read result on the clock edge that samples `bus_rd`, and it holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| raw_tilt_x | input | 16 | Raw X sensor reading, two's complement |
| raw_tilt_y | input | 16 | Raw Y sensor reading, two's complement |
| eep_dout | input | 1 | Data-out line from the serial EEPROM |
| bus_rdata | output | 8 | Registered read data |
| rom_bank | output | 7 | ROM bank number |
| sample_stb | output | 1 | One-cycle sensor sample request |
| eep_pins | output | 8 | EEPROM pin byte (bit 7 select, bit 6 clock, bit 1 data-in) |

## Verification
Each result is due a fixed number of edges after its stimulus. The bank, the keys and the pin byte change on the edge that samples the write. `sample_stb` is high for the whole cycle after the fire write. The holding registers load on the edge at the end of that strobe cycle. `bus_rdata` is valid in the cycle after `bus_rd`. A behavioural model in the bench steps on the same rising edges and is compared with every output at each falling edge. Directed checks sample in the task at the falling edge that follows the access, so a strobe or a read result is seen in exactly the cycle it is due.

// File: rtl/tiltcart_pkg.sv
package tiltcart_pkg;

    typedef enum logic [1:0] {
        ACC_LOCKED = 2'd0,
        ACC_KEY_A  = 2'd1,
        ACC_KEY_B  = 2'd2,
        ACC_OPEN   = 2'd3
    } acc_state_e;

    typedef enum logic [1:0] {
        SMP_IDLE  = 2'd0,
        SMP_ARMED = 2'd1,
        SMP_FIRE  = 2'd2
    } smp_state_e;

    localparam logic [3:0] REG_ARM  = 4'h0;
    localparam logic [3:0] REG_FIRE = 4'h1;
    localparam logic [3:0] REG_XLO  = 4'h2;
    localparam logic [3:0] REG_XHI  = 4'h3;
    localparam logic [3:0] REG_YLO  = 4'h4;
    localparam logic [3:0] REG_YHI  = 4'h5;
    localparam logic [3:0] REG_ZERO = 4'h6;
    localparam logic [3:0] REG_PINS = 4'h8;

    localparam int PIN_CS  = 7;
    localparam int PIN_CLK = 6;
    localparam int PIN_DI  = 1;
    localparam int PIN_DO  = 0;

    localparam logic [15:0] TILT_CENTRE = 16'h81D0;

endpackage

// File: rtl/tc_access.sv
module tc_access
    import tiltcart_pkg::*;
#(
    parameter int          DW            = 8,
    parameter int          BANK_W        = 7,
    parameter logic [2:0]  KEY_A_REGION  = 3'd0,
    parameter logic [2:0]  BANK_REGION   = 3'd1,
    parameter logic [2:0]  KEY_B_REGION  = 3'd2,
    parameter logic [DW-1:0] KEY_A_VAL   = 8'h0A,
    parameter logic [DW-1:0] KEY_B_VAL   = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        region,
    input  logic [DW-1:0]     wdata,
    output logic              unlocked,
    output logic [BANK_W-1:0] bank
);

    localparam logic [BANK_W-1:0] BANK_RESET = BANK_W'(1);

    acc_state_e st_q, st_d;

    logic key_a_wr, key_b_wr, bank_wr;
    assign key_a_wr = wr_en && (region == KEY_A_REGION);
    assign key_b_wr = wr_en && (region == KEY_B_REGION);
    assign bank_wr  = wr_en && (region == BANK_REGION);

    always_comb begin
        st_d = st_q;
        if (key_a_wr) begin
            if (wdata == KEY_A_VAL) begin
                unique case (st_q)
                    ACC_LOCKED: st_d = ACC_KEY_A;
                    ACC_KEY_A:  st_d = ACC_KEY_A;
                    ACC_KEY_B:  st_d = ACC_OPEN;
                    ACC_OPEN:   st_d = ACC_OPEN;
                endcase
            end else begin
                st_d = ACC_LOCKED;
            end
        end else if (key_b_wr) begin
            if (wdata == KEY_B_VAL) begin
                unique case (st_q)
                    ACC_LOCKED: st_d = ACC_KEY_B;
                    ACC_KEY_A:  st_d = ACC_OPEN;
                    ACC_KEY_B:  st_d = ACC_KEY_B;
                    ACC_OPEN:   st_d = ACC_OPEN;
                endcase
            end else begin
                unique case (st_q)
                    ACC_LOCKED: st_d = ACC_LOCKED;
                    ACC_KEY_A:  st_d = ACC_KEY_A;
                    ACC_KEY_B:  st_d = ACC_LOCKED;
                    ACC_OPEN:   st_d = ACC_KEY_A;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ACC_LOCKED;
        else        st_q <= st_d;
    end

    always_comb begin
        unlocked = (st_q == ACC_OPEN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       bank <= BANK_RESET;
        else if (bank_wr) bank <= wdata[BANK_W-1:0];
    end

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_wr |=> $stable(bank)); // R4
    AST_KEY_A_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_a_wr && wdata != KEY_A_VAL) |=> !unlocked); // R2
    AST_KEY_B_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (key_b_wr && wdata != KEY_B_VAL) |=> !unlocked); // R3

endmodule

// File: rtl/tc_sample_seq.sv
module tc_sample_seq
    import tiltcart_pkg::*;
#(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] ARM_MASK  = 8'h55,
    parameter logic [DW-1:0] FIRE_MASK = 8'hAA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_wr,
    input  logic          fire_wr,
    input  logic [DW-1:0] wdata,
    output logic          armed,
    output logic          sample_stb
);

    smp_state_e st_q, st_d;

    logic arm_ok, fire_ok;
    assign arm_ok  = (wdata & ARM_MASK)  == ARM_MASK;
    assign fire_ok = (wdata & FIRE_MASK) == FIRE_MASK;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SMP_IDLE, SMP_FIRE: begin
                if (arm_wr && arm_ok) st_d = SMP_ARMED;
                else                  st_d = SMP_IDLE;
            end
            SMP_ARMED: begin
                if (arm_wr)       st_d = arm_ok  ? SMP_ARMED : SMP_IDLE;
                else if (fire_wr) st_d = fire_ok ? SMP_FIRE  : SMP_IDLE;
            end
            default: st_d = SMP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SMP_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        armed      = (st_q == SMP_ARMED);
        sample_stb = (st_q == SMP_FIRE);
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R7
    AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_wr |=> !armed); // R7
    AST_ARM_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(arm_wr && arm_ok)); // R6

endmodule

// File: rtl/tc_tilt_hold.sv
module tc_tilt_hold #(
    parameter int            TW     = 16,
    parameter logic [TW-1:0] CENTRE = 16'h81D0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [TW-1:0] raw_x,
    input  logic [TW-1:0] raw_y,
    output logic [TW-1:0] x_val,
    output logic [TW-1:0] y_val
);

    logic [TW-1:0] raw_q [2];
    logic [TW-1:0] hold_q [2];

    assign raw_q[0] = raw_x;
    assign raw_q[1] = raw_y;

    for (genvar g = 0; g < 2; g++) begin : g_axis
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       hold_q[g] <= CENTRE;
            else if (capture) hold_q[g] <= CENTRE - raw_q[g];
        end
    end

    assign x_val = hold_q[0];
    assign y_val = hold_q[1];

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(x_val) && $stable(y_val))); // R8

endmodule

// File: rtl/tc_readmux.sv
module tc_readmux
    import tiltcart_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          open_win,
    input  logic [3:0]    idx,
    input  logic [TW-1:0] x_val,
    input  logic [TW-1:0] y_val,
    input  logic [DW-1:0] pin_rd,
    output logic [DW-1:0] rdata
);

    localparam logic [DW-1:0] FILL = '1;

    logic [DW-1:0] sel_d;

    always_comb begin
        sel_d = FILL;
        if (open_win) begin
            case (idx)
                REG_XLO:  sel_d = x_val[DW-1:0];
                REG_XHI:  sel_d = x_val[2*DW-1:DW];
                REG_YLO:  sel_d = y_val[DW-1:0];
                REG_YHI:  sel_d = y_val[2*DW-1:DW];
                REG_ZERO: sel_d = '0;
                REG_PINS: sel_d = pin_rd;
                default:  sel_d = FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= FILL;
        else if (rd_en) rdata <= sel_d;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R12
    AST_CLOSED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !open_win) |=> (rdata == FILL)); // R5

endmodule

// File: rtl/tiltcart_regs.sv
module tiltcart_regs
    import tiltcart_pkg::*;
#(
    parameter int         AW         = 16,
    parameter int         DW         = 8,
    parameter int         BANK_W     = 7,
    parameter int         TW         = 16,
    parameter logic [2:0] WIN_REGION = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [TW-1:0]     raw_tilt_x,
    input  logic [TW-1:0]     raw_tilt_y,
    input  logic              eep_dout,
    output logic [DW-1:0]     bus_rdata,
    output logic [BANK_W-1:0] rom_bank,
    output logic              sample_stb,
    output logic [DW-1:0]     eep_pins
);

    localparam int IDX_LSB   = 4;
    localparam int NUM_DRIVE = 3;
    localparam int DRIVE_POS [NUM_DRIVE] = '{PIN_CS, PIN_CLK, PIN_DI};

    logic [2:0] region;
    logic [3:0] idx;
    logic       unlocked, in_win, open_win, win_wr;
    logic       arm_wr, fire_wr, pins_wr, armed;
    logic [TW-1:0] x_val, y_val;
    logic [NUM_DRIVE-1:0] drive_q;
    logic [DW-1:0] pin_rd;

    assign region   = bus_addr[AW-1:AW-3];
    assign idx      = bus_addr[IDX_LSB+3:IDX_LSB];
    assign in_win   = (region == WIN_REGION);
    assign open_win = in_win && unlocked;
    assign win_wr   = bus_wr && open_win;
    assign arm_wr   = win_wr && (idx == REG_ARM);
    assign fire_wr  = win_wr && (idx == REG_FIRE);
    assign pins_wr  = win_wr && (idx == REG_PINS);

    tc_access #(.DW(DW), .BANK_W(BANK_W)) access_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .region   (region),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .bank     (rom_bank)
    );

    tc_sample_seq #(.DW(DW)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_wr     (arm_wr),
        .fire_wr    (fire_wr),
        .wdata      (bus_wdata),
        .armed      (armed),
        .sample_stb (sample_stb)
    );

    tc_tilt_hold #(.TW(TW), .CENTRE(TILT_CENTRE)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (sample_stb),
        .raw_x   (raw_tilt_x),
        .raw_y   (raw_tilt_y),
        .x_val   (x_val),
        .y_val   (y_val)
    );

    for (genvar g = 0; g < NUM_DRIVE; g++) begin : g_drive
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       drive_q[g] <= 1'b0;
            else if (pins_wr) drive_q[g] <= bus_wdata[DRIVE_POS[g]];
        end
    end

    always_comb begin
        eep_pins = '0;
        for (int i = 0; i < NUM_DRIVE; i++) begin
            eep_pins[DRIVE_POS[i]] = drive_q[i];
        end
        pin_rd         = eep_pins;
        pin_rd[PIN_DO] = eep_dout;
    end

    tc_readmux #(.DW(DW), .TW(TW)) rmux_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_rd),
        .open_win (open_win),
        .idx      (idx),
        .x_val    (x_val),
        .y_val    (y_val),
        .pin_rd   (pin_rd),
        .rdata    (bus_rdata)
    );

    AST_CLOSED_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !unlocked) |=> $stable(eep_pins)); // R5
    AST_STB_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(unlocked)); // R5
    AST_PINS_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_wr |=> $stable(eep_pins)); // R11

endmodule

// File: tb/tiltcart_regs_tb_top.sv
module tiltcart_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] rawx = '0, rawy = '0;
    logic        dout = 1'b0;
    logic [7:0]  rdata;
    logic [6:0]  bank;
    logic        stb;
    logic [7:0]  pins;

    always #4 clk = ~clk;

    tiltcart_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
        .bus_wr(wr), .bus_rd(rd), .raw_tilt_x(rawx), .raw_tilt_y(rawy),
        .eep_dout(dout), .bus_rdata(rdata), .rom_bank(bank),
        .sample_stb(stb), .eep_pins(pins)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    bit          m_ka = 0, m_kb = 0, m_armed = 0, m_stb = 0;
    logic [6:0]  m_bank = 7'd1;
    logic [15:0] m_tx = 16'h81D0, m_ty = 16'h81D0;
    logic [7:0]  m_pins = 8'h00, m_rd = 8'hFF;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ka = 0; m_kb = 0; m_armed = 0; m_stb = 0; m_bank = 7'd1;
            m_tx = 16'h81D0; m_ty = 16'h81D0; m_pins = 8'h00; m_rd = 8'hFF;
        end else begin
            bit nstb;
            bit openw;
            nstb  = 0;
            openw = m_ka && m_kb && (addr[15:13] == 3'd5);
            if (rd) begin
                if (!openw) m_rd = 8'hFF;
                else begin
                    case (addr[7:4])
                        4'h2: m_rd = m_tx[7:0];
                        4'h3: m_rd = m_tx[15:8];
                        4'h4: m_rd = m_ty[7:0];
                        4'h5: m_rd = m_ty[15:8];
                        4'h6: m_rd = 8'h00;
                        4'h8: m_rd = {m_pins[7:1], dout};
                        default: m_rd = 8'hFF;
                    endcase
                end
            end
            if (m_stb) begin
                m_tx = 16'h81D0 - rawx;
                m_ty = 16'h81D0 - rawy;
            end
            if (wr) begin
                case (addr[15:13])
                    3'd0: if (wdata == 8'h0A) m_ka = 1; else begin m_ka = 0; m_kb = 0; end
                    3'd1: m_bank = wdata[6:0];
                    3'd2: m_kb = (wdata == 8'h40);
                    3'd5: if (openw) begin
                        if (addr[7:4] == 4'h0) m_armed = ((wdata & 8'h55) == 8'h55);
                        else if (addr[7:4] == 4'h1) begin
                            nstb = m_armed && ((wdata & 8'hAA) == 8'hAA);
                            m_armed = 0;
                        end else if (addr[7:4] == 4'h8) m_pins = wdata & 8'hC2;
                    end
                    default: ;
                endcase
            end
            m_stb = nstb;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 bank vs model", bank, m_bank);
            check("R7 strobe vs model", stb, m_stb);
            check("R11 pins vs model", pins, m_pins);
            check("R12 rdata vs model", rdata, m_rd);
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); #1 addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); #1 wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk); #1 addr = a; rd = 1'b1;
        @(negedge clk);
        check(tag, rdata, exp);
        #1 rd = 1'b0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 50000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=<50000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        check("R1 bank reset", bank, 7'd1);
        check("R1 strobe reset", stb, 1'b0);
        check("R1 pins reset", pins, 8'h00);
        check("R1 rdata reset", rdata, 8'hFF);
        // R5 locked window
        rd_chk("R5 locked read of zero reg", 16'hA060, 8'hFF);
        bus_wr(16'hA080, 8'hFF);
        check("R5 locked pin write ignored", pins, 8'h00);
        bus_wr(16'hA000, 8'h55);
        bus_wr(16'hA010, 8'hAA);
        check("R5 locked fire ignored", stb, 1'b0);
        // R2/R3 unlock
        bus_wr(16'h0000, 8'h0A);
        rd_chk("R2 only key A still locked", 16'hA060, 8'hFF);
        bus_wr(16'h4000, 8'h40);
        rd_chk("R3 both keys opens window", 16'hA060, 8'h00);
        // R4 bank
        bus_wr(16'h2000, 8'hFF);
        check("R4 bank masked", bank, 7'h7F);
        bus_wr(16'h3FFF, 8'h05);
        check("R4 bank load", bank, 7'h05);
        // R11 pins
        bus_wr(16'hA080, 8'hFF);
        check("R11 pins drive", pins, 8'hC2);
        dout = 1'b1;
        rd_chk("R11 pin readback with dout", 16'hA080, 8'hC3);
        dout = 1'b0;
        bus_wr(16'hA085, 8'h3D);
        check("R11 pins clear", pins, 8'h00);
        bus_wr(16'hA080, 8'h80);
        rd_chk("R11 pin readback select only", 16'hA080, 8'h80);
        // R6/R7/R8/R9 sample
        rawx = 16'h0010; rawy = 16'hFF00;
        bus_wr(16'hA000, 8'h55);
        bus_wr(16'hA010, 8'hAA);
        check("R7 strobe fires", stb, 1'b1);
        rd_chk("R9 X low", 16'hA020, 8'hC0);
        rd_chk("R9 X high", 16'hA030, 8'h81);
        rd_chk("R9 Y low", 16'hA040, 8'hD0);
        rd_chk("R9 Y high", 16'hA050, 8'h82);
        rawx = 16'h8000; rawy = 16'h7FFF;
        rd_chk("R8 X held without strobe", 16'hA020, 8'hC0);
        bus_wr(16'hA000, 8'h54);
        bus_wr(16'hA010, 8'hFF);
        check("R6 partial arm pattern no fire", stb, 1'b0);
        bus_wr(16'hA000, 8'hFF);
        bus_wr(16'hA010, 8'h2A);
        check("R7 bad fire pattern", stb, 1'b0);
        bus_wr(16'hA010, 8'hAA);
        check("R7 latch cleared after bad fire", stb, 1'b0);
        bus_wr(16'hA000, 8'h55);
        bus_wr(16'hA080, 8'h00);
        bus_wr(16'hA010, 8'hEE);
        check("R6 arm survives other write", stb, 1'b1);
        rd_chk("R8 new X low", 16'hA020, 8'hD0);
        rd_chk("R8 new X high", 16'hA030, 8'h01);
        rd_chk("R8 new Y low", 16'hA040, 8'hD1);
        rd_chk("R8 new Y high", 16'hA050, 8'h01);
        // R10 other registers
        rd_chk("R10 reg 0 reads FF", 16'hA000, 8'hFF);
        rd_chk("R10 reg 1 reads FF", 16'hA010, 8'hFF);
        rd_chk("R10 reg 7 reads FF", 16'hA070, 8'hFF);
        rd_chk("R10 reg F reads FF", 16'hBFF0, 8'hFF);
        // R3 key B clear
        bus_wr(16'h5000, 8'h41);
        rd_chk("R3 key B cleared", 16'hA060, 8'hFF);
        bus_wr(16'h4000, 8'h40);
        rd_chk("R3 key B restored", 16'hA060, 8'h00);
        // R2 key A reject clears both
        bus_wr(16'h1000, 8'h00);
        bus_wr(16'h0000, 8'h0A);
        rd_chk("R2 reject cleared both keys", 16'hA060, 8'hFF);
        bus_wr(16'h4000, 8'h40);
        rd_chk("R2 reopen after both keys", 16'h0A060 & 16'hFFFF, 8'h00);
        // R12 hold
        repeat (4) @(negedge clk);
        check("R12 rdata held", rdata, 8'h00);
        finish_run();
    end

endmodule